// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Cache

This block holds recently used virtual-to-physical page translations so that a memory access does not have to consult the page tables each time. A requester presents a 32-bit virtual address and an address-space identifier. The upper 20 bits (the virtual page number) and the identifier are compared against every stored entry at once. On a match, the block returns a 32-bit physical address and the stored protection bits in the same cycle. The physical address is the cached frame number with the low 12 offset bits of the request appended. If nothing matches, the block raises a miss.

Some other agent resolves a miss and then installs the translation through the fill port. A fill uses an empty slot when one exists. When the cache is full, it replaces the entry that was used least recently. Because every entry carries an address-space tag, a context switch can keep entries from other processes. Three maintenance operations remove stale entries: dropping one translation (for example after its protection changes), dropping every entry of one process, and emptying the whole cache.

Top module: `tlb_cache`

## Requirements
- R1: With `lk_valid` high, if a valid entry holds the same page number (`lk_vaddr[31:12]`) and the same `lk_pid`, then in that same cycle `lk_hit` is 1, `lk_paddr` equals `{stored frame, lk_vaddr[11:0]}` and `lk_prot` equals the stored protection.
- R2: With `lk_valid` high and no matching entry, `lk_miss` is 1 and `lk_hit` is 0. With `lk_valid` low, both are 0.
- R3: An entry whose process tag differs from `lk_pid` never produces a hit, even when the page number is equal.
- R4: A fill is visible to a lookup in the following cycle. While a slot is empty, a fill goes to the empty slot with the lowest index.
- R5: When all 16 slots are valid, a fill of a new translation replaces the entry least recently touched. Both a lookup hit and a fill count as a touch. When a fill and a hit fall in the same cycle, only the fill counts.
- R6: A fill whose page number and process tag already exist overwrites that entry. It uses no second slot, and from then on lookups return the new frame and protection.
- R7: A single-entry invalidate removes only the entry that matches both `inv_vpn` and `inv_pid`.
- R8: `flush_all` empties every slot in one cycle.
- R9: A per-process flush removes exactly the entries tagged with `flush_pid`. Entries of other processes stay.
- R10: Within one cycle the operations rank flush_all > per-process flush > invalidate > fill. Only the highest-ranked request takes effect.
- R11: After reset, every slot is empty and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | 8 | Lookup process tag |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup found no entry |
| lk_paddr | output | 32 | Translated address (zero unless hit) |
| lk_prot | output | 3 | Protection bits of the matched entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_pid | input | 8 | Process tag to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_prot | input | 3 | Protection bits to install |
| inv_valid | input | 1 | Invalidate one translation |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_pid | input | 8 | Process tag to invalidate |
| flush_all | input | 1 | Empty the whole cache |
| flush_pid_valid | input | 1 | Remove all entries of one process |
| flush_pid | input | 8 | Process tag to remove |

## Verification
The properties assume that inputs are held at zero while reset is asserted. They also assume that a fill, invalidate or flush request stands for exactly one cycle, so the effect can be traced from the following cycle.

The bench drives every request at the falling edge and releases it after one rising edge. In random traffic it issues at most one maintenance or fill request per cycle. It places same-cycle combinations of requests only in directed cases that check the ranking.

Page numbers and tags come from a small pool, so hits, duplicate fills, evictions and per-process flushes all occur often.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int PID_W  = 8;
    localparam int PROT_W = 3;

    typedef struct packed {
        logic              valid;
        logic [PID_W-1:0]  pid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PROT_W-1:0] prot;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FLUSH_ALL,
        OP_FLUSH_PID,
        OP_INVAL,
        OP_FILL
    } tlb_op_e;

    function automatic logic tag_eq(tlb_entry_t e, logic [VPN_W-1:0] v,
                                    logic [PID_W-1:0] p);
        return e.valid && (e.vpn == v) && (e.pid == p);
    endfunction

    // Ranking of same-cycle maintenance requests
    function automatic tlb_op_e pick_op(logic fa, logic fp, logic iv, logic fl);
        if (fa)      return OP_FLUSH_ALL;
        else if (fp) return OP_FLUSH_PID;
        else if (iv) return OP_INVAL;
        else if (fl) return OP_FILL;
        else         return OP_NONE;
    endfunction
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match import tlb_pkg::*; #(
    parameter int N = 16
) (
    input  tlb_entry_t         ent_i [N],
    input  logic [VPN_W-1:0]   vpn_i,
    input  logic [PID_W-1:0]   pid_i,
    output logic [N-1:0]       vec_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign vec_o[g] = tag_eq(ent_i[g], vpn_i, pid_i);
    end
endmodule

// File: rtl/tlb_pick.sv
`timescale 1ns/1ps
module tlb_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Lowest set bit wins
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/tlb_lru.sv
`timescale 1ns/1ps
module tlb_lru #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim_o
);
    // Age rank per slot: 0 = most recent, N-1 = oldest; always a permutation
    logic [IW-1:0] age_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_o = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == IW'(N - 1)) victim_o = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store import tlb_pkg::*; #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  tlb_op_e           op_i,
    input  logic [IW-1:0]     tgt_idx_i,
    input  tlb_entry_t        new_i,
    input  logic [N-1:0]      inv_vec_i,
    input  logic [PID_W-1:0]  flush_pid_i,
    output tlb_entry_t        ent_o [N]
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_o[g] <= '0;
            end else begin
                unique case (op_i)
                    OP_FLUSH_ALL: ent_o[g].valid <= 1'b0;
                    OP_FLUSH_PID: if (ent_o[g].pid == flush_pid_i) ent_o[g].valid <= 1'b0;
                    OP_INVAL:     if (inv_vec_i[g]) ent_o[g].valid <= 1'b0;
                    OP_FILL:      if (tgt_idx_i == IW'(g)) ent_o[g] <= new_i;
                    default:      ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tlb_cache.sv
`timescale 1ns/1ps
module tlb_cache import tlb_pkg::*; #(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PROT_W-1:0] lk_prot,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid,
    input  logic              flush_all,
    input  logic              flush_pid_valid,
    input  logic [PID_W-1:0]  flush_pid
);
    localparam int IW = $clog2(ENTRIES);

    tlb_entry_t          ent [ENTRIES];
    logic [ENTRIES-1:0]  hit_vec, fill_vec, inv_vec, free_vec;
    logic                look_any, fill_any, free_any;
    logic [IW-1:0]       look_idx, fill_idx, free_idx, victim_idx, tgt_idx;
    logic                touch_en;
    logic [IW-1:0]       touch_idx;
    tlb_op_e             op;
    tlb_entry_t          new_ent;
    logic [VPN_W-1:0]    lk_vpn;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_free
        assign free_vec[g] = ~ent[g].valid;
    end

    tlb_match #(.N(ENTRIES)) u_look_cmp (.ent_i(ent), .vpn_i(lk_vpn),   .pid_i(lk_pid),   .vec_o(hit_vec));
    tlb_match #(.N(ENTRIES)) u_fill_cmp (.ent_i(ent), .vpn_i(fill_vpn), .pid_i(fill_pid), .vec_o(fill_vec));
    tlb_match #(.N(ENTRIES)) u_inv_cmp  (.ent_i(ent), .vpn_i(inv_vpn),  .pid_i(inv_pid),  .vec_o(inv_vec));

    tlb_pick #(.N(ENTRIES), .IW(IW)) u_look_pick (.vec_i(hit_vec),  .any_o(look_any), .idx_o(look_idx));
    tlb_pick #(.N(ENTRIES), .IW(IW)) u_fill_pick (.vec_i(fill_vec), .any_o(fill_any), .idx_o(fill_idx));
    tlb_pick #(.N(ENTRIES), .IW(IW)) u_free_pick (.vec_i(free_vec), .any_o(free_any), .idx_o(free_idx));

    // Lookup result, combinational on stored state
    always_comb begin
        lk_hit   = lk_valid & look_any;
        lk_miss  = lk_valid & ~look_any;
        lk_paddr = '0;
        lk_prot  = '0;
        if (lk_hit) begin
            lk_paddr = {ent[look_idx].pfn, lk_vaddr[OFF_W-1:0]};
            lk_prot  = ent[look_idx].prot;
        end
    end

    // Maintenance ranking and fill slot choice
    always_comb begin
        op      = pick_op(flush_all, flush_pid_valid, inv_valid, fill_valid);
        new_ent = '{valid: 1'b1, pid: fill_pid, vpn: fill_vpn, pfn: fill_pfn, prot: fill_prot};
        if (fill_any)      tgt_idx = fill_idx;
        else if (free_any) tgt_idx = free_idx;
        else               tgt_idx = victim_idx;
        touch_en  = (op == OP_FILL) | lk_hit;
        touch_idx = (op == OP_FILL) ? tgt_idx : look_idx;
    end

    tlb_lru #(.N(ENTRIES), .IW(IW)) u_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx), .victim_o(victim_idx)
    );

    tlb_store #(.N(ENTRIES), .IW(IW)) u_store (
        .clk(clk), .rst(rst), .op_i(op), .tgt_idx_i(tgt_idx), .new_i(new_ent),
        .inv_vec_i(inv_vec), .flush_pid_i(flush_pid), .ent_o(ent)
    );
endmodule

// File: rtl/tlb_cache_chk.sv
`timescale 1ns/1ps
module tlb_cache_chk import tlb_pkg::*; #(
    parameter int N = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [PID_W-1:0]  lk_pid,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic [PA_W-1:0]   lk_paddr,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [PID_W-1:0]  fill_pid,
    input logic              inv_valid,
    input logic [VPN_W-1:0]  inv_vpn,
    input logic [PID_W-1:0]  inv_pid,
    input logic              flush_all,
    input logic              flush_pid_valid,
    input logic [PID_W-1:0]  flush_pid,
    input logic [N-1:0]      hit_vec
);
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_hit != lk_miss));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));

    assert_fill_visible_R4: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !flush_all && !flush_pid_valid && !inv_valid) |=>
        (!(lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn) && lk_pid == $past(fill_pid)) || lk_hit));

    assert_no_dup_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_inval_R7: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !flush_all && !flush_pid_valid) |=>
        !(lk_hit && lk_vaddr[VA_W-1:OFF_W] == $past(inv_vpn) && lk_pid == $past(inv_pid)));

    assert_flush_all_R8: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !lk_hit);

    assert_flush_pid_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_pid_valid && !flush_all) |=> !(lk_hit && lk_pid == $past(flush_pid)));
endmodule

bind tlb_cache tlb_cache_chk #(.N(ENTRIES)) chk_i (.*);

// File: tb/tlb_cache_tb_top.sv
`timescale 1ns/1ps
module tlb_cache_tb_top;
    import tlb_pkg::*;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst;
    logic              lk_valid, lk_hit, lk_miss;
    logic [VA_W-1:0]   lk_vaddr;
    logic [PID_W-1:0]  lk_pid, fill_pid, inv_pid, flush_pid;
    logic [PA_W-1:0]   lk_paddr;
    logic [PROT_W-1:0] lk_prot, fill_prot;
    logic              fill_valid, inv_valid, flush_all, flush_pid_valid;
    logic [VPN_W-1:0]  fill_vpn, inv_vpn;
    logic [PFN_W-1:0]  fill_pfn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tlb_cache dut_i (.*);

    // Reference state
    bit                m_v    [N];
    logic [PID_W-1:0]  m_pid  [N];
    logic [VPN_W-1:0]  m_vpn  [N];
    logic [PFN_W-1:0]  m_pfn  [N];
    logic [PROT_W-1:0] m_prot [N];
    int                order[$];   // front = most recent, back = oldest

    function automatic void touch(int k);
        foreach (order[j]) if (order[j] == k) begin order.delete(j); break; end
        order.push_front(k);
    endfunction

    task automatic idle();
        lk_valid = 0; lk_vaddr = '0; lk_pid = '0;
        fill_valid = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0; fill_prot = '0;
        inv_valid = 0; inv_vpn = '0; inv_pid = '0;
        flush_all = 0; flush_pid_valid = 0; flush_pid = '0;
    endtask

    task automatic set_look(logic [VPN_W-1:0] v, logic [PID_W-1:0] p);
        logic [31:0] r;
        r = $urandom;
        lk_valid = 1; lk_vaddr = {v, r[OFF_W-1:0]}; lk_pid = p;
    endtask

    task automatic set_fill(logic [VPN_W-1:0] v, logic [PID_W-1:0] p,
                            logic [PFN_W-1:0] f, logic [PROT_W-1:0] pr);
        fill_valid = 1; fill_vpn = v; fill_pid = p; fill_pfn = f; fill_prot = pr;
    endtask

    // One clock: check lookup before the edge, update reference after it
    task automatic run_cycle(string tag);
        int hi;
        int t;
        bit eh;
        bit filled;
        hi = -1;
        filled = 0;
        #1;
        if (lk_valid) begin
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == lk_vaddr[VA_W-1:OFF_W] && m_pid[i] == lk_pid) hi = i;
            eh = (hi >= 0);
            n_chk++;
            if (lk_hit !== eh || lk_miss !== !eh ||
                (eh && (lk_paddr !== {m_pfn[hi], lk_vaddr[OFF_W-1:0]} || lk_prot !== m_prot[hi]))) begin
                n_fail++;
                $display("FAIL %s: hit=%0b miss=%0b paddr=%h prot=%0d expected hit=%0b paddr=%h prot=%0d",
                         tag, lk_hit, lk_miss, lk_paddr, lk_prot, eh,
                         eh ? {m_pfn[hi], lk_vaddr[OFF_W-1:0]} : 32'h0, eh ? m_prot[hi] : 3'd0);
            end
        end else begin
            n_chk++;
            if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
                n_fail++;
                $display("FAIL %s R2 idle: hit=%0b miss=%0b expected 0 0", tag, lk_hit, lk_miss);
            end
        end
        @(posedge clk);
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (flush_pid_valid) begin
            for (int i = 0; i < N; i++) if (m_pid[i] == flush_pid) m_v[i] = 0;
        end else if (inv_valid) begin
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == inv_vpn && m_pid[i] == inv_pid) m_v[i] = 0;
        end else if (fill_valid) begin
            t = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == fill_vpn && m_pid[i] == fill_pid) t = i;
            if (t < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) t = i;
            if (t < 0) t = order[$];
            m_v[t] = 1; m_vpn[t] = fill_vpn; m_pid[t] = fill_pid;
            m_pfn[t] = fill_pfn; m_prot[t] = fill_prot;
            touch(t);
            filled = 1;
        end
        if (!filled && hi >= 0) touch(hi);
        @(negedge clk);
        idle();
    endtask

    task automatic look(logic [VPN_W-1:0] v, logic [PID_W-1:0] p, string tag);
        set_look(v, p);
        run_cycle(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        idle();
        for (int i = 0; i < N; i++) begin m_v[i] = 0; order.push_back(i); end
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R11: empty after reset
        for (int i = 0; i < 4; i++) look(20'(i), 8'd1, "R11 reset empty");

        // R4: fill every slot, R1: lookups hit with right frame
        for (int i = 0; i < N; i++) begin
            set_fill(20'h100 + 20'(i), 8'd1, 20'hA0000 + 20'(i), 3'(i));
            run_cycle("R4 fill");
        end
        for (int i = 0; i < N; i++) look(20'h100 + 20'(i), 8'd1, "R1 hit after fill");
        // R3: same page, other process
        look(20'h100, 8'd2, "R3 pid mismatch");

        // R5: touch slot 0, then new fill evicts page 0x101
        look(20'h100, 8'd1, "R1 touch");
        set_fill(20'h200, 8'd1, 20'hBEEF1, 3'd5);
        run_cycle("R5 evict fill");
        look(20'h101, 8'd1, "R5 oldest evicted");
        look(20'h100, 8'd1, "R5 recent kept");
        look(20'h200, 8'd1, "R5 new present");

        // R6: overwrite existing translation
        set_fill(20'h100, 8'd1, 20'h12345, 3'd7);
        run_cycle("R6 overwrite");
        look(20'h100, 8'd1, "R6 new frame");
        for (int i = 2; i < N; i++) look(20'h100 + 20'(i), 8'd1, "R6 others intact");

        // R7: single invalidate
        inv_valid = 1; inv_vpn = 20'h103; inv_pid = 8'd1;
        run_cycle("R7 inval");
        look(20'h103, 8'd1, "R7 removed");
        look(20'h104, 8'd1, "R7 neighbour kept");

        // R9: per-process flush
        set_fill(20'h100, 8'd2, 20'h22222, 3'd2); run_cycle("R4 pid2 fill");
        set_fill(20'h300, 8'd3, 20'h33333, 3'd3); run_cycle("R4 pid3 fill");
        flush_pid_valid = 1; flush_pid = 8'd1;
        run_cycle("R9 flush pid");
        look(20'h100, 8'd1, "R9 pid1 gone");
        look(20'h200, 8'd1, "R9 pid1 gone");
        look(20'h100, 8'd2, "R9 pid2 kept");
        look(20'h300, 8'd3, "R9 pid3 kept");

        // R10: ranking of same-cycle requests
        set_fill(20'h400, 8'd4, 20'h44444, 3'd4);
        inv_valid = 1; inv_vpn = 20'h100; inv_pid = 8'd2;
        run_cycle("R10 inval beats fill");
        look(20'h400, 8'd4, "R10 fill dropped");
        look(20'h100, 8'd2, "R10 inval applied");
        inv_valid = 1; inv_vpn = 20'h300; inv_pid = 8'd3;
        flush_pid_valid = 1; flush_pid = 8'd9;
        run_cycle("R10 pid flush beats inval");
        look(20'h300, 8'd3, "R10 inval dropped");

        // R8: flush_all, with a fill in the same cycle (R10)
        set_fill(20'h500, 8'd5, 20'h55555, 3'd1);
        flush_all = 1;
        run_cycle("R8 flush all");
        look(20'h500, 8'd5, "R10 fill lost to flush");
        look(20'h300, 8'd3, "R8 emptied");

        // Random traffic: R1 R2 R3 R4 R5 R6 R7 R9
        for (int c = 0; c < 4000; c++) begin
            int k;
            r = $urandom;
            if (r[1:0] != 2'b00) set_look(20'(r[6:2] % 24), 8'(r[8:7] % 3));
            k = int'($urandom % 100);
            r = $urandom;
            if (k < 30) set_fill(20'(r[4:0] % 24), 8'(r[6:5] % 3), r[26:7], r[29:27]);
            else if (k < 36) begin inv_valid = 1; inv_vpn = 20'(r[4:0] % 24); inv_pid = 8'(r[6:5] % 3); end
            else if (k < 39) begin flush_pid_valid = 1; flush_pid = 8'(r[6:5] % 3); end
            else if (k < 40) flush_all = 1;
            run_cycle("R1-random R5 R6 R7 R9 mix");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule